// File: doc/BRIEF.md
# Streaming Top-Three and Mean Unit

This block watches a short burst of unsigned samples and reports four summary results about it: the arithmetic mean and the three largest values seen, ranked from largest to third largest. A one-cycle start pulse opens a run. The first sample is expected on the clock after that pulse, and exactly K = 2^LOG2_K samples follow, one per clock. The block keeps a running sum that cannot overflow. It also keeps a sorted list of the three largest values, updated in the same cycle as each sample is added to the sum.

When the last sample has been taken, a done flag rises. A two-bit select input then picks which of the four results appears on the data output. The results and the done flag hold until the next start pulse, so a consumer can step the select input through all four results at its own pace. The mean is the sum divided by K, truncated, which is a plain right shift by LOG2_K bits.

Top module: `run_stats`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0 for every value of `sel`.
- R2: After a `start` pulse at clock edge E0, the samples on `din` are taken at edges E1 through EK. `done` is 0 while they are presented and reads 1 right after edge EK.
- R3: A start pulse clears the sum and all three ranked values to zero, so earlier runs have no effect on the results of a new run.
- R4: For each sample, comparisons are strict. If the sample exceeds the largest value, the ranks shift down and the sample becomes largest. Otherwise, if it exceeds the second value, the second value moves to third and the sample becomes second. Otherwise, if it exceeds the third value, it replaces the third.
- R5: The mean is the (DATA_W+LOG2_K)-bit sum of the K samples shifted right by LOG2_K bits. Even when every sample is all ones, the sum does not wrap.
- R6: `sel` encodes the result shown: 2'b00 the mean, 2'b01 the largest, 2'b10 the second largest, 2'b11 the third largest.
- R7: Once `done` is 1, it stays 1 and all results stay unchanged until the next start pulse, whatever `din` does.
- R8: A start pulse that arrives while samples are still being taken is ignored. The run continues, its results are unchanged, and `done` still rises right after edge EK.
- R9: At every cycle, the largest value is at least the second, and the second is at least the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse; the first sample follows on the next cycle |
| din | input | DATA_W | Sample input, unsigned |
| sel | input | 2 | Result select (see R6) |
| result | output | DATA_W | Selected result |
| done | output | 1 | Results valid; held until the next start |

## Verification
With the start pulse taken at edge E0 and the last sample at edge EK, all four results and `done` are due right after EK, because each passes through one register stage. The bench drives every input on the falling edge. It checks that `done` is low on each falling edge that presents a sample and high on the falling edge that follows EK. Only after that does it release the expected mean and ranks to the scoreboard. The monitor steps `sel` through the expected entries on later falling edges and compares `result` a short delay later, since `result` is a combinational select of held registers.

// File: rtl/run_stats_pkg.sv
package run_stats_pkg;
  typedef enum logic [1:0] {
    SEL_MEAN   = 2'b00,
    SEL_FIRST  = 2'b01,
    SEL_SECOND = 2'b10,
    SEL_THIRD  = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } state_e;
endpackage

// File: rtl/run_stats_ctrl.sv
module run_stats_ctrl
  import run_stats_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic clr,
  output logic take,
  output logic done
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_RUN;
      ST_RUN:  if (last)  state_d = ST_DONE;
      ST_DONE: if (start) state_d = ST_RUN;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign clr  = start && (state_q != ST_RUN);
  assign take = (state_q == ST_RUN);
  assign done = (state_q == ST_DONE);

  // R8
  run_keeps_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !last) |=> (state_q == ST_RUN));
  // R2
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && last) |=> done);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: rtl/run_stats_accum.sv
module run_stats_accum #(
  parameter int DATA_W = 8,
  parameter int LOG2_K = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              last,
  output logic [DATA_W-1:0] mean
);
  localparam int SUM_W = DATA_W + LOG2_K;
  localparam logic [LOG2_K-1:0] CNT_LAST = {LOG2_K{1'b1}};

  logic [SUM_W-1:0]  sum_q, sum_d;
  logic [LOG2_K-1:0] cnt_q, cnt_d;
  logic              sum_en, cnt_en;

  assign sum_en = clr || take;
  assign cnt_en = clr || take;

  always_comb begin
    sum_d = sum_q;
    cnt_d = cnt_q;
    if (clr) begin
      sum_d = '0;
      cnt_d = '0;
    end else if (take) begin
      sum_d = sum_q + SUM_W'(din);
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = take && (cnt_q == CNT_LAST);
  assign mean = sum_q[SUM_W-1:LOG2_K];

  // R5
  sum_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (sum_q >= $past(sum_q)));
  // R3
  sum_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0 && cnt_q == '0));
endmodule

// File: rtl/run_stats_rank.sv
module run_stats_rank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] first,
  output logic [DATA_W-1:0] second,
  output logic [DATA_W-1:0] third
);
  localparam int RANKS = 3;

  logic [DATA_W-1:0] rank_q [RANKS];
  logic [DATA_W-1:0] rank_d [RANKS];
  logic [RANKS-1:0]  above;
  logic              upd;

  generate
    for (genvar g = 0; g < RANKS; g++) begin : g_cmp
      assign above[g] = din > rank_q[g];
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < RANKS; r++) rank_d[r] = rank_q[r];
    if (clr) begin
      for (int r = 0; r < RANKS; r++) rank_d[r] = '0;
    end else if (take) begin
      if (above[0]) begin
        rank_d[2] = rank_q[1];
        rank_d[1] = rank_q[0];
        rank_d[0] = din;
      end else if (above[1]) begin
        rank_d[2] = rank_q[1];
        rank_d[1] = din;
      end else if (above[2]) begin
        rank_d[2] = din;
      end
    end
  end

  assign upd = clr || take;

  generate
    for (genvar g = 0; g < RANKS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   rank_q[g] <= '0;
        else if (upd) rank_q[g] <= rank_d[g];
      end
    end
  endgenerate

  assign first  = rank_q[0];
  assign second = rank_q[1];
  assign third  = rank_q[2];

  // R9
  rank_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first >= second) && (second >= third));
  // R3
  rank_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (first == '0 && second == '0 && third == '0));
  // R4
  new_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && din > first) |=> (first == $past(din) && second == $past(first)));
endmodule

// File: rtl/run_stats.sv
module run_stats
  import run_stats_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOG2_K = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              clr, take, last;
  logic [DATA_W-1:0] mean, first, second, third;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  run_stats_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .last(last),
    .clr(clr), .take(take), .done(done)
  );

  run_stats_accum #(.DATA_W(DATA_W), .LOG2_K(LOG2_K)) u_accum (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .take(take), .din(din),
    .last(last), .mean(mean)
  );

  run_stats_rank #(.DATA_W(DATA_W)) u_rank (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .take(take), .din(din),
    .first(first), .second(second), .third(third)
  );

  always_comb begin
    case (sel_e'(sel))
      SEL_MEAN:   result = mean;
      SEL_FIRST:  result = first;
      SEL_SECOND: result = second;
      SEL_THIRD:  result = third;
      default:    result = mean;
    endcase
  end

  // R6
  sel_first_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == 2'b01) |-> (result == first));
endmodule

// File: tb/tb_run_stats.sv
module tb_run_stats;
  localparam int DW = 8;
  localparam int LK = 3;
  localparam int K  = 1 << LK;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] din = '0;
  logic [1:0]    sel = 2'b00;
  logic [DW-1:0] result;
  logic          done;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  typedef struct {
    logic [1:0]    mode;
    logic [DW-1:0] val;
    int            rq;
  } exp_t;
  exp_t q[$];

  run_stats #(.DATA_W(DW), .LOG2_K(LK)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .sel(sel), .result(result), .done(done)
  );

  always #10 clk = ~clk;

  task automatic check(input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected items while done, drives sel and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && done) begin
        exp_t it;
        it = q.pop_front();
        sel = it.mode;
        #2;
        check(it.rq, result, it.val);
      end
    end
  end

  // expected results from the requirements (R4 insertion, R5 mean)
  task automatic push_expected(input logic [DW-1:0] s [K], input int rq_rank);
    logic [DW-1:0]    a, b, c;
    logic [DW+LK-1:0] sum;
    a = '0; b = '0; c = '0; sum = '0;
    for (int i = 0; i < K; i++) begin
      sum = sum + (DW+LK)'(s[i]);
      if (s[i] > a)      begin c = b; b = a; a = s[i]; end
      else if (s[i] > b) begin c = b; b = s[i]; end
      else if (s[i] > c) c = s[i];
    end
    q.push_back('{2'b00, sum[DW+LK-1:LK], 5});  // R5 via mode 00 (R6)
    q.push_back('{2'b01, a, rq_rank});
    q.push_back('{2'b10, b, rq_rank});
    q.push_back('{2'b11, c, rq_rank});
  endtask

  task automatic wait_drained();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: one run, optional stray start mid-run (R8)
  task automatic run_block(input logic [DW-1:0] s [K], input bit stray, input int rq_rank);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < K; i++) begin
      din   = s[i];
      start = (stray && i == 3);
      check(2, {7'd0, done}, 8'd0);   // R2: done low during samples
      @(negedge clk);
    end
    start = 1'b0;
    din   = 8'hA5;
    check(2, {7'd0, done}, 8'd1);     // R2: done high right after EK
    push_expected(s, rq_rank);
    wait_drained();
  endtask

  initial begin
    logic [DW-1:0] s [K];
    // R1: reset state
    repeat (2) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      sel = 2'(m);
      #2;
      check(1, result, 8'd0);
    end
    check(1, {7'd0, done}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1, {7'd0, done}, 8'd0);

    // ascending: top 8,7,6, mean 36>>3 = 4 (R4, R6)
    for (int i = 0; i < K; i++) s[i] = 8'(i + 1);
    run_block(s, 1'b0, 4);

    // R7: hold while din changes
    for (int i = 0; i < 5; i++) begin din = 8'(i * 37 + 200); @(negedge clk); end
    check(7, {7'd0, done}, 8'd1);
    push_expected(s, 7);
    wait_drained();

    // descending with duplicates (R4: strict compares)
    s = '{8'd90, 8'd90, 8'd40, 8'd90, 8'd12, 8'd77, 8'd40, 8'd3};
    run_block(s, 1'b0, 4);

    // mixed pattern, new max arrives late (R4)
    s = '{8'd10, 8'd50, 8'd30, 8'd20, 8'd45, 8'd60, 8'd5, 8'd200};
    run_block(s, 1'b0, 4);

    // all ones: no wrap of the sum (R5)
    for (int i = 0; i < K; i++) s[i] = 8'hFF;
    run_block(s, 1'b0, 5);

    // all zeros right after: earlier results cleared (R3)
    for (int i = 0; i < K; i++) s[i] = 8'h00;
    run_block(s, 1'b0, 3);

    // stray start mid-run ignored (R8)
    s = '{8'd7, 8'd130, 8'd64, 8'd129, 8'd1, 8'd2, 8'd250, 8'd99};
    run_block(s, 1'b1, 8);

    finish_run();
  end

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end
endmodule